// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic use an external asynchronous static RAM of 512K words by 8 bits. A request port takes one access at a time through a valid/ready handshake. Each access carries a read/write flag, a 19-bit word address and 8 bits of write data. The controller plays the access out on the memory pins as a fixed series of clock-cycle phases. It drives the active-low chip enable, write enable and output enable, holds the address, and controls a shared data bus through separate out, in and driver-enable signals. Every timing rule of the memory becomes a whole number of clock cycles, set by a parameter and rounded up from the nanosecond value.

Back-pressure works as follows. `req_ready` is high only while the controller is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the whole access has finished, including any bus-turnaround wait, and the request inputs are ignored for that time. The response side has no ready signal. The consumer must take `rsp_rdata` in the single cycle in which `rsp_valid` is high. A write returns no response.

A write drives data on the bus from the start of its setup phase. It then pulls chip enable and write enable low together, releases them together, and keeps address and data on the pins for a recovery phase. A read pulls chip enable and output enable low and samples the bus in its last strobe cycle. After a read the bus must be left undriven for a set number of cycles, so that the memory's output drivers are off before the controller drives write data.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all three strobes are high, `mem_dq_oe` is 0 and `rsp_valid` is 0. After release `req_ready` is 1, and the bus counts as already quiet.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is 0 from the next cycle until the access is complete, and it is 1 again in the first cycle after the access.
- R3: `mem_addr` takes the request's address at acceptance and holds it until the next acceptance. It changes only at an edge where both `mem_ce_n` and `mem_we_n` are high before and after the edge.
- R4: A write occupies SETUP_CYC cycles with all strobes high and data driven, then WPULSE_CYC cycles with `mem_ce_n` and `mem_we_n` low, `mem_oe_n` high and the data stable, then WREC_CYC cycles after both strobes rise on the same edge, with address and data still driven. Without a turnaround wait, `req_ready` is low for SETUP_CYC+WPULSE_CYC+WREC_CYC cycles.
- R5: A read occupies SETUP_CYC cycles with all strobes high, then RACC_CYC cycles with `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high. `mem_dq_in` is sampled at the edge that ends the last of these cycles. `rsp_valid` is high for exactly one cycle, the first cycle after the strobes rise, and carries that sample. `req_ready` is low for SETUP_CYC+RACC_CYC cycles.
- R6: `mem_dq_oe` is 1 only during the three write phases. It is never 1 while `mem_oe_n` is low.
- R7: After the last cycle in which the memory drove the bus (`mem_ce_n` and `mem_oe_n` both low), `mem_dq_oe` stays 0 for at least TURN_CYC cycles. A write that is taken sooner waits in an extra phase with all strobes high, and `req_ready` stays low during it. If a write is taken in the k-th cycle after the read (k counted from 0), it is delayed by max(0, TURN_CYC-(k+1)) cycles.
- R8: A write never produces a `rsp_valid` pulse.
- R9: While `req_ready` is 0, changes on `req_valid`, `req_write`, `req_addr` and `req_wdata` have no effect on the memory pins or on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W (8) | Read data |
| mem_addr | output | ADDR_W (19) | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | DATA_W (8) | Data toward the memory |
| mem_dq_in | input | DATA_W (8) | Data from the memory |
| mem_dq_oe | output | 1 | Driver enable for `mem_dq_out` |

## Verification
Every pin changes on the edge that ends the acceptance cycle. The first phase therefore shows at the pins in the cycle right after acceptance, and `req_ready` returns exactly SETUP_CYC+WPULSE_CYC+WREC_CYC cycles later for a write (plus any turnaround delay) and SETUP_CYC+RACC_CYC cycles later for a read. In that same returning cycle `rsp_valid` carries a read's data. The bench works out each expected busy length beforehand from the cycle in which the last read ended. It samples on falling edges, so it counts busy cycles, strobe-low cycles and the held address one whole cycle at a time. The memory model returns valid data only in the last access cycle, so a sample taken one edge early reads the filler value.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_WSET,
    PH_WSTB,
    PH_WEND,
    PH_RSET,
    PH_RSTB
  } phase_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_turn_guard.sv
module asram_turn_guard #(
  parameter int TURN_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_held,
  output logic drive_ok_next
);

  localparam int TW = $clog2(TURN_CYC + 1);
  localparam logic [TW-1:0] LIM = TW'(TURN_CYC);

  logic [TW-1:0] quiet_q, quiet_d;

  always_comb begin
    if (bus_held) begin
      quiet_d = '0;
    end else if (quiet_q < LIM) begin
      quiet_d = quiet_q + 1'b1;
    end else begin
      quiet_d = quiet_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= LIM;
    end else begin
      quiet_q <= quiet_d;
    end
  end

  assign drive_ok_next = (quiet_d >= LIM);

endmodule

// File: rtl/asram_pin_drive.sv
module asram_pin_drive
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_d,
  input  logic              take,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cap,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic strobe_ce, strobe_we, strobe_oe, drive_bus;

  always_comb begin
    strobe_ce = (phase_d == PH_WSTB) || (phase_d == PH_RSTB);
    strobe_we = (phase_d == PH_WSTB);
    strobe_oe = (phase_d == PH_RSTB);
    drive_bus = (phase_d == PH_WSET) || (phase_d == PH_WSTB) || (phase_d == PH_WEND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      mem_ce_n  <= !strobe_ce;
      mem_we_n  <= !strobe_we;
      mem_oe_n  <= !strobe_oe;
      mem_dq_oe <= drive_bus;
      if (take) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      rsp_valid <= cap;
      if (cap) begin
        rsp_rdata <= mem_dq_in;
      end
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int WPULSE_CYC = 1,
  parameter int WREC_CYC   = 1,
  parameter int RACC_CYC   = 2,
  parameter int TURN_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int LEN_MAX = max4(SETUP_CYC, WPULSE_CYC, WREC_CYC, RACC_CYC);
  localparam int CNT_W   = $clog2(LEN_MAX + 1);
  localparam logic [CNT_W-1:0] LEN_SET = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_WP  = CNT_W'(WPULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_REC = CNT_W'(WREC_CYC - 1);
  localparam logic [CNT_W-1:0] LEN_ACC = CNT_W'(RACC_CYC - 1);

  phase_e           phase_q, phase_d;
  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  logic             take, cap;
  logic             drive_ok_next;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  asram_turn_guard #(.TURN_CYC(TURN_CYC)) u_turn (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_held      (phase_q == PH_RSTB),
    .drive_ok_next (drive_ok_next)
  );

  // Phase sequencer: each timed phase loads the timer on entry.
  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take     = 1'b0;
    cap      = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          take     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LEN_SET;
          if (!req_write)        phase_d = PH_RSET;
          else if (drive_ok_next) phase_d = PH_WSET;
          else                   phase_d = PH_TURN;
        end
      end
      PH_TURN: begin
        if (drive_ok_next) begin
          phase_d  = PH_WSET;
          tmr_load = 1'b1;
          tmr_val  = LEN_SET;
        end
      end
      PH_WSET: begin
        if (tmr_last) begin
          phase_d  = PH_WSTB;
          tmr_load = 1'b1;
          tmr_val  = LEN_WP;
        end
      end
      PH_WSTB: begin
        if (tmr_last) begin
          phase_d  = PH_WEND;
          tmr_load = 1'b1;
          tmr_val  = LEN_REC;
        end
      end
      PH_WEND: begin
        if (tmr_last) phase_d = PH_IDLE;
      end
      PH_RSET: begin
        if (tmr_last) begin
          phase_d  = PH_RSTB;
          tmr_load = 1'b1;
          tmr_val  = LEN_ACC;
        end
      end
      PH_RSTB: begin
        if (tmr_last) begin
          phase_d = PH_IDLE;
          cap     = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign req_ready = (phase_q == PH_IDLE);

  asram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_d    (phase_d),
    .take       (take),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .cap        (cap),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int WPULSE_CYC = 1,
  parameter int TURN_CYC   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  logic [15:0] wlow_cnt;
  logic [15:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlow_cnt  <= '0;
      quiet_cnt <= 16'(TURN_CYC);
    end else begin
      if (!mem_we_n) begin
        if (wlow_cnt != 16'hFFFF) wlow_cnt <= wlow_cnt + 1'b1;
      end else begin
        wlow_cnt <= '0;
      end
      if (!mem_ce_n && !mem_oe_n) quiet_cnt <= '0;
      else if (quiet_cnt < 16'(TURN_CYC)) quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

  assert_addr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |->
      (mem_ce_n && mem_we_n && $past(mem_ce_n) && $past(mem_we_n)));

  assert_write_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  assert_wdata_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_dq_out));

  assert_joint_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $rose(mem_ce_n));

  assert_wpulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow_cnt == 16'(WPULSE_CYC)));

  assert_read_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!$past(mem_oe_n) && mem_oe_n));

  assert_turn_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (quiet_cnt >= 16'(TURN_CYC)));

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .WPULSE_CYC (WPULSE_CYC),
  .TURN_CYC   (TURN_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
  localparam int AW   = 19;
  localparam int DW   = 8;
  localparam int SET  = 1;
  localparam int WP   = 2;
  localparam int REC  = 1;
  localparam int RD   = 2;
  localparam int TURN = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = 8'hA5;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SET), .WPULSE_CYC(WP),
    .WREC_CYC(REC), .RACC_CYC(RD), .TURN_CYC(TURN)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  // Memory model: data is valid only from the RD-th access cycle on.
  logic [DW-1:0] store [int];
  bit            wr_prev = 0;
  logic [AW-1:0] wa_prev = '0;
  logic [DW-1:0] wd_prev = '0;
  int            rd_cnt = 0;

  always @(negedge clk) begin
    if (wr_prev && !(!mem_ce_n && !mem_we_n)) store[int'(wa_prev)] = wd_prev;
    wr_prev = !mem_ce_n && !mem_we_n;
    wa_prev = mem_addr;
    wd_prev = mem_dq_out;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt++;
    else rd_cnt = 0;
    if (rd_cnt >= RD)
      mem_dq_in = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : '0;
    else
      mem_dq_in = 8'hA5;
  end

  // Scoreboard
  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] exp_v;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe)
        check_eq("R6", "bus driven while memory drives",
                 longint'(!mem_ce_n && !mem_oe_n && mem_we_n), 0);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check_eq("R8", "unexpected response", 1, 0);
        end else begin
          exp_v = exp_q.pop_front();
          check_eq("R5", "read data", rsp_rdata, exp_v);
        end
      end
    end
  end

  bit have_rd = 0;
  int last_rd_cyc = 0;

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int gap, input string tag);
    int busy, exp_busy, quiet, strb;
    repeat (gap) @(negedge clk);
    while (!req_ready) @(negedge clk);
    quiet = have_rd ? (cyc - last_rd_cyc) : 1000;
    if (wr) begin
      exp_busy = SET + WP + REC + ((quiet + 1 < TURN) ? TURN - (quiet + 1) : 0);
      shadow[int'(a)] = d;
    end else begin
      exp_busy = SET + RD;
      exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : '0);
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    busy = 0; strb = 0;
    while (!req_ready) begin
      busy++;
      check_eq("R9", "address held while busy", mem_addr, a);
      if (wr ? !mem_we_n : !mem_oe_n) strb++;
      req_addr = ~a; req_wdata = ~d; req_write = !wr;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check_eq(tag, "busy cycles", busy, exp_busy);
    check_eq(wr ? "R4" : "R5", "strobe-low cycles", strb, wr ? WP : RD);
    check_eq("R2", "ready back", req_ready, 1);
    if (!wr) begin
      have_rd = 1;
      last_rd_cyc = cyc;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1", "ce_n in reset", mem_ce_n, 1);
    check_eq("R1", "we_n in reset", mem_we_n, 1);
    check_eq("R1", "oe_n in reset", mem_oe_n, 1);
    check_eq("R1", "dq_oe in reset", mem_dq_oe, 0);
    check_eq("R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "ready after reset", req_ready, 1);
    check_eq("R1", "ce_n after reset", mem_ce_n, 1);

    xfer(1, 19'h00000, 8'h3C, 0, "R4");
    xfer(1, 19'h7FFFF, 8'hC3, 2, "R4");
    xfer(1, 19'h12345, 8'h99, 0, "R4");
    xfer(1, 19'h55555, 8'h01, 1, "R4");
    xfer(0, 19'h00000, 8'h00, 0, "R5");
    xfer(0, 19'h7FFFF, 8'h00, 0, "R5");
    xfer(0, 19'h12345, 8'h00, 3, "R5");
    xfer(0, 19'h55555, 8'h00, 0, "R5");
    xfer(1, 19'h00010, 8'h77, 0, "R7");  // read then write at once
    xfer(0, 19'h00010, 8'h00, 0, "R5");
    xfer(1, 19'h00020, 8'h5E, 1, "R7");  // one idle cycle covers the turnaround
    xfer(0, 19'h2AAAA, 8'h00, 0, "R5");  // never written
    xfer(1, 19'h00000, 8'hE1, 0, "R7");
    xfer(0, 19'h00000, 8'h00, 0, "R5");
    xfer(0, 19'h00020, 8'h00, 0, "R5");

    repeat (6) @(negedge clk);
    check_eq("R5", "responses outstanding", exp_q.size(), 0);
    check_eq("R8", "rsp_valid idle", rsp_valid, 0);
    summary();
    $finish;
  end

endmodule